// File: doc/BRIEF.md
# SPI Burst Master

A full-duplex serial peripheral master that moves a counted burst of bytes between two byte FIFOs and a serial link. A 32-bit register port fills the transmit FIFO and programs a byte count for the burst and a byte count for transmit data. Writing the exchange bit starts the burst. For every byte shifted out, most significant bit first, one byte is shifted in and queued in the receive FIFO. Software polls the receive count in the status word until the burst has arrived, then reads the bytes out.

The serial clock rate comes from outside. Each pulse on `sclk_tick_i` advances the serial clock by one half-period, so a byte takes sixteen ticks. Clock polarity and phase are programmable. Four chip-select outputs are under direct software control. A level bit drives the selected line, and a polarity bit sets the idle level of all the other lines.

Register map (word address on `addr_i`):
- 0 control: bit 0 enable, bit 1 master.
- 1 transfer: bit 0 CPHA, bit 1 CPOL, bit 2 active-low select, bits 5:4 target select, bit 6 select level, bit 7 exchange / busy.
- 2 FIFO control: bit 0 empties TX, bit 1 empties RX. Both are write-only pulses.
- 3 status: bits 15:0 RX count, bits 31:16 TX count.
- 4 burst count.
- 5 transmit count.
- 6 TX data push.
- 7 RX data pop. A read pops one byte and returns 0 when the FIFO is empty.

Top module: `spi_burst_master`

## Requirements
- R1: A burst starts only while control bits 0 (enable) and 1 (master) are both set. Clearing either bit during a burst stops it on the next cycle, and an exchange write made while either bit is clear leaves bit 7 of the transfer word at 0.
- R2: The burst count (address 4) and transmit count (address 5) keep bits 23:0 of a write and read back 0 in bits 31:24.
- R3: Setting bit 7 of the transfer word with a nonzero burst count makes bit 7 read 1 until the last bit of the final byte has been sampled. After that it reads 0 by itself.
- R4: Each byte is sent MSB first. Byte j of a burst is the next TX FIFO byte if j is below the transmit count and the FIFO holds data. Otherwise byte j is 0x00.
- R5: Each byte sent produces exactly one received byte in the RX FIFO, and reads of address 7 return those bytes in arrival order.
- R6: The status word gives the RX count in bits 15:0 and the TX count in bits 31:16. Neither count exceeds the FIFO depth: a push to a full FIFO is dropped, and receive bytes arriving at a full RX FIFO are lost.
- R7: The selected chip-select output equals the level bit (transfer bit 6), whatever the value of the active-low bit (transfer bit 2).
- R8: Transfer bits 5:4 pick one of the four chip-select outputs. Every other output sits at the inactive level, which is 1 when bit 2 is set and 0 when it is clear.
- R9: Writing FIFO-control bit 0 empties the TX FIFO, and bit 1 empties the RX FIFO. The matching count reads 0 on the next access.
- R10: The serial clock idles at CPOL and makes exactly 16 transitions per byte. Data is sampled on the leading edge when CPHA is 0 and on the trailing edge when CPHA is 1, and MOSI never changes on a sampling edge.
- R11: An exchange write with a burst count of zero sends nothing and leaves both FIFOs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as the access |
| sclk_tick_i | input | 1 | Half-period pulse for the serial clock |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_miso_i | input | 1 | Serial data in |
| spi_cs_o | output | 4 | Chip-select lines |

## Verification
The assertions check every cycle that:
- the idle serial clock sits at CPOL and MOSI holds still across every sampling edge;
- a burst never starts or continues while the controller is disabled;
- at most one chip-select line is away from its inactive level;
- both FIFO counts stay within the depth;
- a FIFO clear leaves its count at zero.

Byte content and order, transmit-count padding, underflow zeros, edge totals per byte, RX saturation on long bursts and the chip-select table can only be shown by the bench's sweeps. These sweeps cover all four clock modes and several load, burst and transmit-count mixes, and the bench checks each case against values it works out itself.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  localparam int unsigned CNT_W    = 24;
  localparam int unsigned CS_SEL_W = 2;
  localparam int unsigned NCS      = 1 << CS_SEL_W;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_XFER  = 3'd1,
    A_FCTL  = 3'd2,
    A_STAT  = 3'd3,
    A_BURST = 3'd4,
    A_XMIT  = 3'd5,
    A_TXD   = 3'd6,
    A_RXD   = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic                cs_lvl;
    logic [CS_SEL_W-1:0] cs_sel;
    logic                act_low;
    logic                cpol;
    logic                cpha;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned WIDTH = 8,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = PW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rptr];
  assign count_o = cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr_i) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] burst_i,
  input  logic [CNT_W-1:0] xmit_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             tick_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_empty_i,
  input  logic             miso_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  logic             busy, sclk_ph, mosi_q;
  logic [3:0]       edge_cnt;
  logic [CNT_W-1:0] bytes_left, xmit_left, xl_cur;
  logic [7:0]       tx_sr, rx_sr, byte_in;
  logic             start_go, edge_ev, last_edge, next_load, take, sample, shift;

  assign start_go  = start_i && !busy && run_i && (burst_i != '0);
  assign edge_ev   = busy && run_i && tick_i;
  assign last_edge = edge_ev && (edge_cnt == 4'd15);
  assign next_load = last_edge && (bytes_left != CNT_W'(1));
  assign xl_cur    = start_go ? xmit_i : xmit_left;
  assign take      = (start_go || next_load) && (xl_cur != '0) && !tx_empty_i;
  assign byte_in   = take ? tx_data_i : 8'h00;
  // sampling edge: leading (even count) for cpha=0, trailing (odd) for cpha=1
  assign sample    = edge_ev && (edge_cnt[0] == cpha_i);
  assign shift     = edge_ev && !sample;

  assign tx_pop_o  = take;
  assign rx_push_o = last_edge;
  assign rx_data_o = cpha_i ? {rx_sr[6:0], miso_i} : rx_sr;
  assign busy_o    = busy;
  assign sclk_o    = cpol_i ^ sclk_ph;
  assign mosi_o    = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy       <= 1'b0;
      sclk_ph    <= 1'b0;
      mosi_q     <= 1'b0;
      edge_cnt   <= '0;
      bytes_left <= '0;
      xmit_left  <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
    end else if (busy && !run_i) begin
      busy     <= 1'b0;
      sclk_ph  <= 1'b0;
      edge_cnt <= '0;
    end else if (start_go) begin
      busy       <= 1'b1;
      sclk_ph    <= 1'b0;
      edge_cnt   <= '0;
      bytes_left <= burst_i;
      xmit_left  <= (xmit_i != '0) ? xmit_i - 1'b1 : '0;
      if (cpha_i) tx_sr <= byte_in;
      else begin
        mosi_q <= byte_in[7];
        tx_sr  <= {byte_in[6:0], 1'b0};
      end
    end else if (edge_ev) begin
      sclk_ph  <= ~sclk_ph;
      edge_cnt <= edge_cnt + 1'b1;
      if (sample) rx_sr <= {rx_sr[6:0], miso_i};
      if (last_edge) begin
        if (next_load) begin
          bytes_left <= bytes_left - 1'b1;
          xmit_left  <= (xmit_left != '0) ? xmit_left - 1'b1 : '0;
          if (cpha_i) tx_sr <= byte_in;
          else begin
            mosi_q <= byte_in[7];
            tx_sr  <= {byte_in[6:0], 1'b0};
          end
        end else begin
          busy <= 1'b0;
        end
      end else if (shift) begin
        mosi_q <= tx_sr[7];
        tx_sr  <= {tx_sr[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
  parameter  int unsigned NCS   = 4,
  localparam int unsigned SEL_W = $clog2(NCS)
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             act_low_i,
  input  logic             level_i,
  output logic [NCS-1:0]   cs_o
);
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_o[i] = (sel_i == SEL_W'(i)) ? level_i : act_low_i;
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter  int unsigned FIFO_DEPTH = 64,
  localparam int unsigned FCW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [2:0]     addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic           sclk_tick_i,
  output logic           spi_sclk_o,
  output logic           spi_mosi_o,
  input  logic           spi_miso_i,
  output logic [NCS-1:0] spi_cs_o
);
  logic             en_q, master_q, run, busy;
  xfer_cfg_t        cfg;
  logic [CNT_W-1:0] burst_q, xmit_q;
  logic             wr, rd, start, tx_clr, rx_clr, tx_push, rx_pop;
  logic             tx_pop, rx_push, tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]       tx_head, rx_head, rx_byte;
  logic [FCW-1:0]   tx_cnt, rx_cnt;
  logic             cfg_cpol, cfg_cpha, cfg_act_low;
  logic [CS_SEL_W-1:0] cfg_cs_sel;
  reg_addr_e        a;

  assign a       = reg_addr_e'(addr_i);
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign run     = en_q && master_q;
  assign start   = wr && (a == A_XFER) && wdata_i[7];
  assign tx_clr  = wr && (a == A_FCTL) && wdata_i[0];
  assign rx_clr  = wr && (a == A_FCTL) && wdata_i[1];
  assign tx_push = wr && (a == A_TXD);
  assign rx_pop  = rd && (a == A_RXD);

  assign cfg_cpol    = cfg.cpol;
  assign cfg_cpha    = cfg.cpha;
  assign cfg_act_low = cfg.act_low;
  assign cfg_cs_sel  = cfg.cs_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      master_q <= 1'b0;
      cfg      <= '0;
      burst_q  <= '0;
      xmit_q   <= '0;
    end else if (wr) begin
      case (a)
        A_CTRL:  {master_q, en_q} <= wdata_i[1:0];
        A_XFER:  cfg <= {wdata_i[6:4], wdata_i[2:0]};
        A_BURST: burst_q <= wdata_i[CNT_W-1:0];
        A_XMIT:  xmit_q  <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (a)
      A_CTRL:  rdata_o = {30'b0, master_q, en_q};
      A_XFER:  rdata_o = {24'b0, busy, cfg.cs_lvl, cfg.cs_sel, 1'b0,
                          cfg.act_low, cfg.cpol, cfg.cpha};
      A_STAT:  rdata_o = {16'(tx_cnt), 16'(rx_cnt)};
      A_BURST: rdata_o = {{(32-CNT_W){1'b0}}, burst_q};
      A_XMIT:  rdata_o = {{(32-CNT_W){1'b0}}, xmit_q};
      A_RXD:   rdata_o = rx_empty ? 32'h0 : {24'b0, rx_head};
      default: rdata_o = '0;
    endcase
  end

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr), .push_i(tx_push), .wdata_i(wdata_i[7:0]),
    .pop_i(tx_pop), .rdata_o(tx_head), .count_o(tx_cnt), .full_o(tx_full),
    .empty_o(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr), .push_i(rx_push), .wdata_i(rx_byte),
    .pop_i(rx_pop), .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full),
    .empty_o(rx_empty)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .burst_i(burst_q),
    .xmit_i(xmit_q), .cpol_i(cfg.cpol), .cpha_i(cfg.cpha), .tick_i(sclk_tick_i),
    .tx_data_i(tx_head), .tx_empty_i(tx_empty), .miso_i(spi_miso_i),
    .tx_pop_o(tx_pop), .rx_push_o(rx_push), .rx_data_o(rx_byte),
    .busy_o(busy), .sclk_o(spi_sclk_o), .mosi_o(spi_mosi_o)
  );

  spi_cs_ctrl #(.NCS(NCS)) u_cs (
    .sel_i(cfg.cs_sel), .act_low_i(cfg.act_low), .level_i(cfg.cs_lvl),
    .cs_o(spi_cs_o)
  );

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:CNT_W], tx_full, rx_full};
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter  int unsigned DEPTH = 64,
  parameter  int unsigned NCS   = 4,
  localparam int unsigned FCW   = $clog2(DEPTH) + 1,
  localparam int unsigned SEL_W = $clog2(NCS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             run,
  input logic             cfg_cpol,
  input logic             cfg_cpha,
  input logic             cfg_act_low,
  input logic [SEL_W-1:0] cfg_cs_sel,
  input logic             spi_sclk_o,
  input logic             spi_mosi_o,
  input logic [NCS-1:0]   spi_cs_o,
  input logic [FCW-1:0]   rx_cnt,
  input logic [FCW-1:0]   tx_cnt,
  input logic             tx_clr,
  input logic             rx_clr
);
  // R10
  idle_sclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> spi_sclk_o == cfg_cpol);

  // R10
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) && (spi_sclk_o != $past(spi_sclk_o)) &&
    ((spi_sclk_o != cfg_cpol) != cfg_cpha) |-> $stable(spi_mosi_o));

  // R1
  start_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(run));

  // R1
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !run |=> !busy);

  // R6
  rx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= FCW'(DEPTH));

  // R6
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= FCW'(DEPTH));

  // R9
  tx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr |=> tx_cnt == '0);

  // R9
  rx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr |=> rx_cnt == '0);

  // R8
  one_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(spi_cs_o ^ {NCS{cfg_act_low}}) <= 1);

  // R8
  sel_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(spi_cs_o ^ {NCS{cfg_act_low}}) == 1 |->
      spi_cs_o[cfg_cs_sel] != cfg_act_low);
endmodule

bind spi_burst_master spi_burst_master_chk #(
  .DEPTH(FIFO_DEPTH), .NCS(spi_burst_pkg::NCS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .run(run),
  .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_act_low(cfg_act_low),
  .cfg_cs_sel(cfg_cs_sel), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o),
  .spi_cs_o(spi_cs_o), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .tx_clr(tx_clr), .rx_clr(rx_clr)
);

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tick;
  logic [1:0]  tdiv = '0;
  logic        sclk, mosi, miso;
  logic [3:0]  cs;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // serial monitor state
  int   edge_n = 0, cap_n = 0, mon_bits = 0;
  logic mon_prev = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  logic [7:0] mon_byte = '0;
  logic [7:0] cap [128];

  always #10 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 1'b1;
  assign tick = (tdiv == 2'd3);
  assign miso = ~mosi;

  spi_burst_master #(.FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_tick_i(tick), .spi_sclk_o(sclk),
    .spi_mosi_o(mosi), .spi_miso_i(miso), .spi_cs_o(cs)
  );

  always @(negedge clk) begin
    if (sclk !== mon_prev) begin
      edge_n++;
      if ((sclk != mon_cpol) != mon_cpha) begin
        mon_byte = {mon_byte[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
          if (cap_n < 128) cap[cap_n] = mon_byte;
          cap_n++;
          mon_bits = 0;
        end
      end
    end
    mon_prev = sclk;
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  function automatic logic [7:0] pat(input int i, input int m);
    return 8'((i * 37 + m * 11 + 5) & 255);
  endfunction

  task automatic wait_idle();
    logic [31:0] d;
    for (int k = 0; k < 6000; k++) begin
      rd(3'd1, d);
      if (!d[7]) break;
    end
  endtask

  task automatic run_burst(input int m, input int nload, input int burst, input int xmit);
    logic [31:0] d, base;
    int L, nrx, popped;
    logic [7:0] e;
    wr(3'd2, 32'h3);
    for (int i = 0; i < nload; i++) wr(3'd6, {24'b0, pat(i, m)});
    wr(3'd4, burst);
    wr(3'd5, xmit);
    base = 32'h4 | (m[1] << 1) | m[0];
    wr(3'd1, base);
    @(negedge clk);
    mon_cpol = m[1]; mon_cpha = m[0]; mon_prev = sclk;
    edge_n = 0; cap_n = 0; mon_bits = 0;
    wr(3'd1, base | 32'h80);
    rd(3'd1, d);
    check("R3 busy after start", {31'b0, d[7]}, 32'd1);
    wait_idle();
    rd(3'd1, d);
    check("R3 self-clear", {31'b0, d[7]}, 32'd0);
    check("R10 edge total", edge_n, 16 * burst);
    check("R10 idle level", {31'b0, sclk}, {31'b0, m[1]});
    check("R5 byte count", cap_n, burst);
    L = (nload < DEPTH) ? nload : DEPTH;
    for (int j = 0; j < burst && j < 128; j++) begin
      e = (j < xmit && j < L) ? pat(j, m) : 8'h00;
      check("R4 mosi byte", {24'b0, cap[j]}, {24'b0, e});
    end
    nrx = (burst < DEPTH) ? burst : DEPTH;
    popped = (xmit < burst) ? xmit : burst;
    if (popped > L) popped = L;
    rd(3'd3, d);
    check("R6 rx count", {16'b0, d[15:0]}, nrx);
    check("R6 tx count", {16'b0, d[31:16]}, L - popped);
    for (int j = 0; j < nrx; j++) begin
      e = (j < xmit && j < L) ? pat(j, m) : 8'h00;
      rd(3'd7, d);
      check("R5 rx byte", d, {24'b0, ~e});
    end
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", d, 32'h0);
    end
    check("R8 reset cs", {28'b0, cs}, 32'h0);
    check("R10 reset sclk", {31'b0, sclk}, 32'h0);

    // R2 count widths
    wr(3'd4, 32'hFF123456); rd(3'd4, d); check("R2 burst mask", d, 32'h00123456);
    wr(3'd5, 32'hAB000010); rd(3'd5, d); check("R2 xmit mask", d, 32'h00000010);

    // R7 R8 exhaustive chip-select table
    for (int s = 0; s < 4; s++)
      for (int al = 0; al < 2; al++)
        for (int lv = 0; lv < 2; lv++) begin
          logic [3:0] exp;
          wr(3'd1, (lv << 6) | (s << 4) | (al << 2));
          for (int i = 0; i < 4; i++) exp[i] = (i == s) ? lv[0] : al[0];
          @(negedge clk);
          check("R7/R8 cs table", {28'b0, cs}, {28'b0, exp});
        end

    // R1 gating: enable only, then master only
    wr(3'd2, 32'h3); wr(3'd6, 32'h5A); wr(3'd4, 1); wr(3'd5, 1);
    for (int c = 1; c < 3; c++) begin
      wr(3'd0, c);
      edge_n = 0;
      wr(3'd1, 32'h80);
      rd(3'd1, d); check("R1 no start", {31'b0, d[7]}, 32'd0);
      rd(3'd3, d); check("R1 tx untouched", {16'b0, d[31:16]}, 32'd1);
    end
    check("R1 no edges", edge_n, 0);

    // R11 zero burst
    wr(3'd0, 32'h3); wr(3'd4, 0);
    wr(3'd1, 32'h80);
    rd(3'd1, d); check("R11 no busy", {31'b0, d[7]}, 32'd0);
    rd(3'd3, d); check("R11 fifos kept", d, 32'h00010000);

    // R9 FIFO clears
    wr(3'd2, 32'h1); rd(3'd3, d); check("R9 tx clear", {16'b0, d[31:16]}, 32'd0);

    // R1 stop mid-burst
    wr(3'd6, 32'hC3); wr(3'd4, 4); wr(3'd5, 4);
    wr(3'd1, 32'h80);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h0);
    rd(3'd1, d); check("R1 stop", {31'b0, d[7]}, 32'd0);
    wr(3'd2, 32'h2); rd(3'd3, d); check("R9 rx clear", {16'b0, d[15:0]}, 32'd0);
    wr(3'd0, 32'h3);

    // sweep modes and load/burst/xmit mixes
    for (int m = 0; m < 4; m++) begin
      run_burst(m, 1, 1, 1);
      run_burst(m, 3, 3, 3);
      run_burst(m, 5, 5, 2);
      run_burst(m, 2, 4, 4);
    end
    // full FIFO drop, underflow padding, RX saturation
    run_burst(0, 65, 70, 70);
    run_burst(3, 64, 66, 60);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule